// File: doc/BRIEF.md
# Touch Keypad Timing Supervisor

This block provides the digital timekeeping that surrounds a capacitive touch keypad front end. It has no analog sensing of its own. From power-on it keeps every function quiet for a settling interval, and then it asks the sensing logic to calibrate. While no key is touched it opens short wake-up sampling windows at a fixed rate. After a long stretch with no touch it requests a fresh calibration, and it keeps doing so for as long as the pad stays untouched. Each reported change of key state produces a data-valid pulse of fixed width, and an option sets that pulse's polarity. A second option enables a stuck-key timeout. When a key stays on too long, the timeout sends the whole keypad back to its power-on state, and the key release that follows produces no data-valid pulse.

All long intervals are counted in ticks of a 1 kHz enable input. The default limits are 500 ticks of settling, 4000 ticks of idle time before recalibration and 80000 ticks of key-on time. The wake-up period is 125 ticks in the slow setting and 16 ticks in the fast setting. A wake-up window is 4 ticks long, or 2 ticks in the short setting. The data-valid pulse is counted in system clocks. Its length is taken from the clock frequency parameter and the pulse duration parameter, which gives 93 clocks at the default 1 MHz.

The controller has five states. SETTLE holds everything off. CAL lasts one cycle and raises the calibration request. SLEEP schedules the wake-up windows. RUN is operation with continuous sampling. REINIT lasts one cycle and raises the reinitialise request. The transitions are:
- SETTLE to CAL when the settle count expires.
- CAL to SLEEP always.
- SLEEP to RUN when any key is on.
- SLEEP or RUN to CAL when the idle count expires.
- RUN to REINIT when the key-on timeout fires.
- REINIT to SETTLE always.

Top module: `touch_timing_sup`

## Requirements
- R1: After reset the block is in SETTLE for SETTLE_TICKS ticks. During SETTLE, sample_en, cal_req and reinit_req are 0 and dv_pin stays at its inactive level.
- R2: cal_req is high for exactly one clock. It rises on the clock after the tick on which the settle count or the idle count expires.
- R3: Once IDLE_TICKS consecutive ticks have passed in SLEEP or RUN with the key vector all zero, cal_req is raised and the block enters SLEEP. This repeats for as long as no key is on, and any key that is on restarts the count.
- R4: In SLEEP, wake-up windows start every SLOW_PERIOD ticks when opt_fast_wake is 0 and every FAST_PERIOD ticks when it is 1. The first window opens on entry to SLEEP.
- R5: In SLEEP, each window holds sample_en high for LONG_WIN ticks when opt_short_win is 0 and for SHORT_WIN ticks when it is 1.
- R6: A non-zero key vector in SLEEP moves the block to RUN. In RUN, sample_en is held high continuously.
- R7: key_chg in SLEEP or RUN starts a data-valid pulse that lasts the derived number of clocks. A new key_chg during a pulse restarts the full width.
- R8: When opt_dv_pol is 1, dv_pin is active-low: it rests at 1 and goes to 0 during a pulse. When opt_dv_pol is 0, dv_pin is active-high: it rests at 0 and goes to 1 during a pulse.
- R9: When opt_keyon_en is 1 and a non-zero key vector has been held in RUN for KEYON_TICKS ticks, reinit_req is raised for one clock and the block then restarts at SETTLE.
- R10: When opt_keyon_en is 0, reinit_req never rises, however long keys stay on.
- R11: key_chg has no effect on dv_pin in SETTLE, CAL or REINIT. This covers the key release that follows a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| tick | input | 1 | 1 kHz time-base enable, one clock wide |
| opt_fast_wake | input | 1 | 1 selects the fast wake-up period |
| opt_short_win | input | 1 | 1 selects the short wake-up window |
| opt_keyon_en | input | 1 | 1 enables the maximum key-on timeout |
| opt_dv_pol | input | 1 | 1 gives an active-low data-valid pulse, 0 gives active-high |
| keys | input | NKEYS | Current key on/off vector, 1 means on |
| key_chg | input | 1 | One-clock flag that the key vector changed |
| sample_en | output | 1 | Sampling enable: windowed in SLEEP, constant in RUN |
| cal_req | output | 1 | One-clock calibration request |
| reinit_req | output | 1 | One-clock request to return the keypad to its initial state |
| dv_pin | output | 1 | Data-valid pin level |

## Verification
The reference model runs through the whole state sequence with ticks arriving once every three clocks. This separates tick-counted intervals from clock-counted ones. Sleep windows are compared with both period settings and both window settings, and a long untouched stretch shows whether recalibration repeats and whether windows restart after each CAL. Key presses and releases in RUN test the pulse width, the restart of a pulse that is already running, and both polarities. A long hold is run first with the timeout off and then with it switched on, which shows that the key-on count saturates and not wraps, and that the release which follows in SETTLE produces no pulse.

// File: rtl/tsup_pkg.sv
package tsup_pkg;
    typedef enum logic [2:0] {
        ST_SETTLE = 3'd0,
        ST_CAL    = 3'd1,
        ST_SLEEP  = 3'd2,
        ST_RUN    = 3'd3,
        ST_REINIT = 3'd4
    } tsup_state_e;
endpackage

// File: rtl/tsup_sat_cnt.sv
module tsup_sat_cnt #(
    parameter int MAX = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_max
);
    localparam int W = (MAX < 1) ? 1 : $clog2(MAX + 1);
    localparam logic [W-1:0] LIMIT = W'(MAX);

    logic [W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && count != LIMIT) begin
            count <= count + 1'b1;
        end
    end

    assign at_max = (count == LIMIT);
endmodule

// File: rtl/tsup_wake_sched.sv
module tsup_wake_sched #(
    parameter int SLOW_PERIOD = 125,
    parameter int FAST_PERIOD = 16,
    parameter int LONG_WIN    = 4,
    parameter int SHORT_WIN   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick,
    input  logic opt_fast,
    input  logic opt_short,
    output logic window
);
    localparam int MAXP = (SLOW_PERIOD > FAST_PERIOD) ? SLOW_PERIOD : FAST_PERIOD;
    localparam int PW   = $clog2(MAXP + 1);

    logic [PW-1:0] phase;
    logic [PW-1:0] last;
    logic [PW-1:0] win_len;

    assign last    = opt_fast  ? PW'(FAST_PERIOD - 1) : PW'(SLOW_PERIOD - 1);
    assign win_len = opt_short ? PW'(SHORT_WIN)       : PW'(LONG_WIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!active) begin
            phase <= '0;
        end else if (tick) begin
            phase <= (phase >= last) ? '0 : phase + 1'b1;
        end
    end

    assign window = active && (phase < win_len);
endmodule

// File: rtl/tsup_dv_pulse.sv
module tsup_dv_pulse #(
    parameter int PULSE_CYC = 93
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic pol_low,
    output logic busy,
    output logic level
);
    localparam int CW = $clog2(PULSE_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (trig) begin
            remain <= LOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy  = (remain != '0);
    assign level = busy ^ pol_low;
endmodule

// File: rtl/touch_timing_sup.sv
module touch_timing_sup
    import tsup_pkg::*;
#(
    parameter int NKEYS        = 16,
    parameter int SETTLE_TICKS = 500,
    parameter int IDLE_TICKS   = 4000,
    parameter int KEYON_TICKS  = 80000,
    parameter int SLOW_PERIOD  = 125,
    parameter int FAST_PERIOD  = 16,
    parameter int LONG_WIN     = 4,
    parameter int SHORT_WIN    = 2,
    parameter int CLK_KHZ      = 1000,
    parameter int DV_NS        = 93000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             opt_fast_wake,
    input  logic             opt_short_win,
    input  logic             opt_keyon_en,
    input  logic             opt_dv_pol,
    input  logic [NKEYS-1:0] keys,
    input  logic             key_chg,
    output logic             sample_en,
    output logic             cal_req,
    output logic             reinit_req,
    output logic             dv_pin
);
    localparam int DV_RAW = (CLK_KHZ * DV_NS) / 1000000;
    localparam int DV_CYC = (DV_RAW < 1) ? 1 : DV_RAW;

    tsup_state_e st, nxt;

    logic keys_any;
    logic settle_done, idle_full, keyon_full;
    logic idle_done, keyon_done;
    logic in_sleep, in_run, awake;
    logic window, dv_active, dv_trig;

    assign keys_any = |keys;
    assign in_sleep = (st == ST_SLEEP);
    assign in_run   = (st == ST_RUN);
    assign awake    = in_sleep || in_run;

    tsup_sat_cnt #(.MAX(SETTLE_TICKS - 1)) u_settle (
        .clk(clk), .rst_n(rst_n),
        .clr(st != ST_SETTLE), .inc(tick), .at_max(settle_done)
    );

    tsup_sat_cnt #(.MAX(IDLE_TICKS - 1)) u_idle (
        .clk(clk), .rst_n(rst_n),
        .clr(!awake || keys_any), .inc(tick), .at_max(idle_full)
    );

    tsup_sat_cnt #(.MAX(KEYON_TICKS - 1)) u_keyon (
        .clk(clk), .rst_n(rst_n),
        .clr(!in_run || !keys_any), .inc(tick), .at_max(keyon_full)
    );

    tsup_wake_sched #(
        .SLOW_PERIOD(SLOW_PERIOD), .FAST_PERIOD(FAST_PERIOD),
        .LONG_WIN(LONG_WIN), .SHORT_WIN(SHORT_WIN)
    ) u_wake (
        .clk(clk), .rst_n(rst_n), .active(in_sleep), .tick(tick),
        .opt_fast(opt_fast_wake), .opt_short(opt_short_win), .window(window)
    );

    assign dv_trig = key_chg && awake;

    tsup_dv_pulse #(.PULSE_CYC(DV_CYC)) u_dv (
        .clk(clk), .rst_n(rst_n), .trig(dv_trig), .pol_low(opt_dv_pol),
        .busy(dv_active), .level(dv_pin)
    );

    assign idle_done  = tick && !keys_any && idle_full;
    assign keyon_done = opt_keyon_en && tick && keys_any && keyon_full;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_SETTLE;
        end else begin
            st <= nxt;
        end
    end

    // Next-state decode
    always_comb begin
        nxt = st;
        unique case (st)
            ST_SETTLE: if (tick && settle_done) nxt = ST_CAL;
            ST_CAL:    nxt = ST_SLEEP;
            ST_SLEEP: begin
                if (keys_any)       nxt = ST_RUN;
                else if (idle_done) nxt = ST_CAL;
            end
            ST_RUN: begin
                if (keyon_done)     nxt = ST_REINIT;
                else if (idle_done) nxt = ST_CAL;
            end
            ST_REINIT: nxt = ST_SETTLE;
            default:   nxt = ST_SETTLE;
        endcase
    end

    // Outputs
    always_comb begin
        cal_req    = 1'b0;
        reinit_req = 1'b0;
        sample_en  = 1'b0;
        unique case (st)
            ST_SETTLE: ;
            ST_CAL:    cal_req = 1'b1;
            ST_SLEEP:  sample_en = window;
            ST_RUN:    sample_en = 1'b1;
            ST_REINIT: reinit_req = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/tsup_checker.sv
module tsup_checker
    import tsup_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input tsup_state_e st,
    input logic        cal_req,
    input logic        reinit_req,
    input logic        sample_en,
    input logic        dv_active,
    input logic        opt_keyon_en
);
    // R1: nothing is sampled or requested while settling
    assert_settle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SETTLE) |-> (!sample_en && !cal_req && !reinit_req))
        else $error("settle not quiet");

    // R2: calibration request is a single clock
    assert_cal_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req |=> !cal_req)
        else $error("cal_req longer than one clock");

    // R6: operation keeps sampling on
    assert_run_sampling_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> sample_en)
        else $error("sampling off in RUN");

    // R9: a reinitialise request is followed by settling
    assert_reinit_settle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_req |=> (st == ST_SETTLE && !reinit_req && !sample_en))
        else $error("reinit not followed by settle");

    // R10: no timeout while the option is off
    assert_keyon_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !opt_keyon_en |=> !reinit_req)
        else $error("reinit with timeout disabled");

    // R11: no pulse starts outside SLEEP and RUN
    assert_dv_no_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_SETTLE || st == ST_CAL || st == ST_REINIT) && !dv_active) |=> !dv_active)
        else $error("data-valid pulse started while inactive");
endmodule

bind touch_timing_sup tsup_checker u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .st(st),
    .cal_req(cal_req),
    .reinit_req(reinit_req),
    .sample_en(sample_en),
    .dv_active(dv_active),
    .opt_keyon_en(opt_keyon_en)
);

// File: tb/sim_touch_timing_sup.sv
module sim_touch_timing_sup;
    localparam int CLK_PERIOD = 10;
    localparam int P_SETTLE = 5;
    localparam int P_IDLE   = 20;
    localparam int P_KEYON  = 30;
    localparam int P_SLOW   = 12;
    localparam int P_FAST   = 5;
    localparam int P_LONG   = 4;
    localparam int P_SHORT  = 2;
    localparam int P_KHZ    = 100;
    localparam int P_DVNS   = 93000;
    localparam int DVC      = 9;   // 100 kHz * 93 us

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic opt_fast_wake = 1'b0, opt_short_win = 1'b0, opt_keyon_en = 1'b0, opt_dv_pol = 1'b1;
    logic [15:0] keys = '0;
    logic key_chg = 1'b0;
    logic sample_en, cal_req, reinit_req, dv_pin;

    int n_checks = 0;
    int n_errors = 0;
    int obs_cal = 0;
    int obs_reinit = 0;
    string cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    touch_timing_sup #(
        .NKEYS(16), .SETTLE_TICKS(P_SETTLE), .IDLE_TICKS(P_IDLE), .KEYON_TICKS(P_KEYON),
        .SLOW_PERIOD(P_SLOW), .FAST_PERIOD(P_FAST), .LONG_WIN(P_LONG), .SHORT_WIN(P_SHORT),
        .CLK_KHZ(P_KHZ), .DV_NS(P_DVNS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .opt_fast_wake(opt_fast_wake), .opt_short_win(opt_short_win),
        .opt_keyon_en(opt_keyon_en), .opt_dv_pol(opt_dv_pol),
        .keys(keys), .key_chg(key_chg),
        .sample_en(sample_en), .cal_req(cal_req), .reinit_req(reinit_req), .dv_pin(dv_pin)
    );

    // Behavioural reference: mode 0 settle, 1 cal, 2 sleep, 3 run, 4 reinit
    int m_mode = 0, m_next = 0;
    int m_settle = 0, m_idle = 0, m_hold = 0, m_phase = 0, m_dv = 0;
    int per = 0;
    logic any_key;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_settle = 0; m_idle = 0; m_hold = 0; m_phase = 0; m_dv = 0;
        end else begin
            any_key = |keys;
            per = opt_fast_wake ? P_FAST : P_SLOW;
            m_next = m_mode;
            case (m_mode)
                0: if (tick && m_settle == P_SETTLE - 1) m_next = 1;
                1: m_next = 2;
                2: if (any_key) m_next = 3;
                   else if (tick && m_idle == P_IDLE - 1) m_next = 1;
                3: if (opt_keyon_en && tick && any_key && m_hold == P_KEYON - 1) m_next = 4;
                   else if (!any_key && tick && m_idle == P_IDLE - 1) m_next = 1;
                default: m_next = 0;
            endcase
            if (m_mode != 0) m_settle = 0;
            else if (tick && m_settle < P_SETTLE - 1) m_settle++;
            if ((m_mode == 2 || m_mode == 3) && !any_key) begin
                if (tick && m_idle < P_IDLE - 1) m_idle++;
            end else m_idle = 0;
            if (m_mode == 3 && any_key) begin
                if (tick && m_hold < P_KEYON - 1) m_hold++;
            end else m_hold = 0;
            if (m_mode != 2) m_phase = 0;
            else if (tick) m_phase = (m_phase >= per - 1) ? 0 : m_phase + 1;
            if (key_chg && (m_mode == 2 || m_mode == 3)) m_dv = DVC;
            else if (m_dv > 0) m_dv--;
            m_mode = m_next;
        end
    end

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_int(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        logic e_samp, e_dv;
        int wl;
        wl = opt_short_win ? P_SHORT : P_LONG;
        e_samp = (m_mode == 3) || (m_mode == 2 && m_phase < wl);
        e_dv = (m_dv > 0) ^ opt_dv_pol;
        if (cal_req) obs_cal++;
        if (reinit_req) obs_reinit++;
        check_bit(cur_tag, "sample_en", sample_en, e_samp);
        check_bit(cur_tag, "cal_req", cal_req, m_mode == 1);
        check_bit(cur_tag, "reinit_req", reinit_req, m_mode == 4);
        check_bit(cur_tag, "dv_pin", dv_pin, e_dv);
    end

    // Tick: one clock in three
    initial begin
        int tc = 0;
        forever begin
            @(negedge clk); #1;
            tc++;
            tick = (tc % 3 == 0);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic change_keys(input logic [15:0] v);
        @(negedge clk); #1;
        keys = v; key_chg = 1'b1;
        @(negedge clk); #1;
        key_chg = 1'b0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        wait_cyc(4);
        // R1: reset state, active-low rest level
        check_bit("R1", "reset sample_en", sample_en, 1'b0);
        check_bit("R1", "reset cal_req", cal_req, 1'b0);
        check_bit("R1", "reset dv_pin", dv_pin, 1'b1);
        rst_n = 1'b1;
        wait_cyc(3);
        cur_tag = "R11";            // key change while settling is ignored
        change_keys(16'h0000);
        wait_cyc(1);
        check_bit("R11", "dv during settle", dv_pin, 1'b1);
        cur_tag = "R2";
        wait_cyc(20);
        check_int("R2", "first calibration count", obs_cal, 1);
        cur_tag = "R4";             // slow period, long window
        wait_cyc(150);
        cur_tag = "R3";
        check_int("R3", "repeated recal seen", (obs_cal >= 3) ? 1 : 0, 1);
        cur_tag = "R5";             // fast period, short window
        opt_fast_wake = 1'b1; opt_short_win = 1'b1;
        wait_cyc(80);
        cur_tag = "R7";
        change_keys(16'h0001);
        wait_cyc(4);
        change_keys(16'h0003);      // retrigger mid-pulse
        wait_cyc(6);
        check_bit("R7", "pulse extended", dv_pin, 1'b0);
        cur_tag = "R6";
        wait_cyc(6);
        check_bit("R6", "run sampling", sample_en, 1'b1);
        cur_tag = "R8";
        opt_dv_pol = 1'b0;
        wait_cyc(1);
        check_bit("R8", "active-high rest", dv_pin, 1'b0);
        change_keys(16'h0000);
        wait_cyc(3);
        check_bit("R8", "active-high pulse", dv_pin, 1'b1);
        cur_tag = "R3";
        wait_cyc(80);
        cur_tag = "R10";
        opt_keyon_en = 1'b0;
        change_keys(16'h0100);
        wait_cyc(130);
        check_int("R10", "no timeout when disabled", obs_reinit, 0);
        cur_tag = "R9";
        opt_keyon_en = 1'b1;
        wait_cyc(10);
        check_int("R9", "timeout fired once", obs_reinit, 1);
        check_bit("R9", "settling after timeout", sample_en, 1'b0);
        cur_tag = "R11";
        change_keys(16'h0000);
        wait_cyc(3);
        check_bit("R11", "no pulse after timeout release", dv_pin, 1'b0);
        wait_cyc(40);
        finish_run();
    end
endmodule